// File: doc/BRIEF.md
# Sensor Frame Timing Generator

This block produces the frame and line strobes that pace an image-sensor readout. On every cycle where the pixel-clock enable is high it advances one pixel through a repeating frame schedule. The schedule runs vertical blanking rows, then an optional run of extra delay pixels, then the active rows. Every row, whether blank or active, starts with its horizontal blanking columns and ends with its active columns. The frame-valid strobe covers the active rows and the line-valid strobe covers the active columns inside them. The block also exposes its row and column counters and a one-cycle start-of-frame pulse for downstream logic.

The block takes seven configuration inputs: active width and height, horizontal blanking, vertical blanking, dark-row count, extra delay and a low-power flag. It clamps horizontal blanking to a minimum that depends on the power mode. It raises vertical blanking to the dark-row count when it is set lower. It captures all of these settings in shadow registers at a single point per frame, so a frame never mixes old and new settings. Software can therefore rewrite the inputs at any time.

Top module: `frame_timing_gen`

## Requirements
- R1: While reset is low, fv, lv and sof are 0 and rowIdx and colIdx are 0. After reset, outputs stay at 0 until the first enabled cycle. That cycle captures the configuration, and the schedule starts counting on the following enabled cycle.
- R2: Every row, blank or active, lasts hEff + wEff enabled cycles, with colIdx running from 0 upward. The first hEff columns are blanking. hEff is the programmed horizontal blanking, or the mode minimum when the programmed value is smaller. The minimum is 202 when lowPower=0 and 114 when lowPower=1.
- R3: lv is 1 exactly in columns hEff to hEff+wEff-1 of active rows. fv is 1 in every column of every active row, from column 0 of the first active row through the last active pixel. Both are 0 at all other times.
- R4: Each frame begins with vEff vertical blanking rows, where vEff is the larger of the vertical blanking and dark-row settings. fv is 0 during these rows and rowIdx counts them from 0. When vEff is 0, no blanking rows are produced.
- R5: The extra delay pixels follow the vertical blanking and come before the first active row. During them rowIdx is 0 and colIdx counts 0 to extraDelay-1. When extraDelay is 0, this phase is skipped.
- R6: Configuration is captured only on the enabled cycle that completes the last active pixel of a frame, and on the first enabled cycle after reset. A change to the inputs at any other time has no effect on the schedule until that capture.
- R7: sof is 1 only during the enabled cycle at row 0, column 0 of the active rows.
- R8: On a cycle where pixEn is 0, fv, lv, rowIdx and colIdx keep their values into the next cycle, and sof is 0.
- R9: An active width or height of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel-clock enable; one pixel advances per high cycle |
| activeWidth | input | COL_W | Active columns per row |
| activeHeight | input | ROW_W | Active rows per frame |
| hBlank | input | HB_W | Horizontal blanking columns requested |
| vBlank | input | VB_W | Vertical blanking rows requested |
| darkRows | input | DARK_W | Dark rows per frame (lower bound on vertical blanking) |
| extraDelay | input | DLY_W | Extra pixels between vertical blanking and the first active row |
| lowPower | input | 1 | Selects the low-power horizontal blanking minimum |
| fv | output | 1 | Frame valid |
| lv | output | 1 | Line valid |
| sof | output | 1 | Start-of-frame pulse |
| rowIdx | output | RCNT_W | Row within the current phase |
| colIdx | output | CCNT_W | Column within the current row, or pixel within the extra delay |

## Verification
Both counters are brought out at the ports, so a wrong phase, clamp or counter value shows up on the very next enabled cycle. It appears as a mismatch in colIdx, rowIdx, fv or lv against a cycle-by-cycle model of the schedule. A shadow register that loaded at the wrong moment changes the length of a row or frame, and the model catches that within the first row of the affected frame. The reference model writes junk values to the configuration inputs in the middle of a frame and inserts idle cycles into the enable. This exposes mid-frame capture and counters that advance while the enable is low.

// File: rtl/frame_timing_pkg.sv
package frame_timing_pkg;

  typedef enum logic [1:0] {
    PH_LOAD   = 2'd0,
    PH_VBLANK = 2'd1,
    PH_EXTRA  = 2'd2,
    PH_ACTIVE = 2'd3
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic colInc;
    logic colClr;
    logic rowInc;
    logic rowClr;
  } strobe_t;

  // Compare results from datapath to control
  typedef struct packed {
    logic colAtRowEnd;
    logic rowAtVEnd;
    logic rowAtActEnd;
    logic colAtDlyEnd;
    logic shDlyNz;
    logic candVbNz;
    logic candDlyNz;
    logic inActiveCols;
    logic atOrigin;
  } status_t;

endpackage

// File: rtl/frame_timing_path.sv
module frame_timing_path
  import frame_timing_pkg::*;
#(
  parameter int COL_W       = 12,
  parameter int ROW_W       = 12,
  parameter int HB_W        = 11,
  parameter int VB_W        = 15,
  parameter int DARK_W      = 8,
  parameter int DLY_W       = 14,
  parameter int HB_MIN_FULL = 202,
  parameter int HB_MIN_LOW  = 114,
  parameter int LEN_W       = ((HB_W > COL_W) ? HB_W : COL_W) + 1,
  parameter int CCNT_W      = (LEN_W > DLY_W) ? LEN_W : DLY_W,
  parameter int VMAX_W      = (VB_W > DARK_W) ? VB_W : DARK_W,
  parameter int RCNT_W      = (VMAX_W > ROW_W) ? VMAX_W : ROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [COL_W-1:0]  activeWidth,
  input  logic [ROW_W-1:0]  activeHeight,
  input  logic [HB_W-1:0]   hBlank,
  input  logic [VB_W-1:0]   vBlank,
  input  logic [DARK_W-1:0] darkRows,
  input  logic [DLY_W-1:0]  extraDelay,
  input  logic              lowPower,
  output status_t           stat,
  output logic [RCNT_W-1:0] rowCnt,
  output logic [CCNT_W-1:0] colCnt
);

  // Candidate (clamped) settings from the live inputs
  logic [HB_W-1:0]   hbMin;
  logic [HB_W-1:0]   candHb;
  logic [RCNT_W-1:0] candVb;
  logic [COL_W-1:0]  candW;
  logic [ROW_W-1:0]  candH;

  always_comb begin
    hbMin  = lowPower ? HB_W'(HB_MIN_LOW) : HB_W'(HB_MIN_FULL);
    candHb = (hBlank < hbMin) ? hbMin : hBlank;
    candVb = (RCNT_W'(vBlank) < RCNT_W'(darkRows)) ? RCNT_W'(darkRows) : RCNT_W'(vBlank);
    candW  = (activeWidth == '0) ? COL_W'(1) : activeWidth;
    candH  = (activeHeight == '0) ? ROW_W'(1) : activeHeight;
  end

  // Shadow registers, loaded once per frame
  logic [HB_W-1:0]   shHb;
  logic [RCNT_W-1:0] shVb;
  logic [COL_W-1:0]  shW;
  logic [ROW_W-1:0]  shH;
  logic [DLY_W-1:0]  shDly;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shHb  <= '0;
      shVb  <= '0;
      shW   <= '0;
      shH   <= '0;
      shDly <= '0;
    end else if (strb.load) begin
      shHb  <= candHb;
      shVb  <= candVb;
      shW   <= candW;
      shH   <= candH;
      shDly <= extraDelay;
    end
  end

  // Column and row counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= '0;
    end else if (strb.colClr) begin
      colCnt <= '0;
    end else if (strb.colInc) begin
      colCnt <= colCnt + CCNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowCnt <= '0;
    end else if (strb.rowClr) begin
      rowCnt <= '0;
    end else if (strb.rowInc) begin
      rowCnt <= rowCnt + RCNT_W'(1);
    end
  end

  // Compares
  logic [LEN_W-1:0] rowLen;

  always_comb begin
    rowLen            = LEN_W'(shHb) + LEN_W'(shW);
    stat.colAtRowEnd  = (colCnt == CCNT_W'(rowLen) - CCNT_W'(1));
    stat.rowAtVEnd    = (rowCnt == shVb - RCNT_W'(1));
    stat.rowAtActEnd  = (rowCnt == RCNT_W'(shH) - RCNT_W'(1));
    stat.colAtDlyEnd  = (colCnt == CCNT_W'(shDly) - CCNT_W'(1));
    stat.shDlyNz      = (shDly != '0);
    stat.candVbNz     = (candVb != '0);
    stat.candDlyNz    = (extraDelay != '0);
    stat.inActiveCols = (colCnt >= CCNT_W'(shHb));
    stat.atOrigin     = (colCnt == '0) && (rowCnt == '0);
  end

endmodule

// File: rtl/frame_timing_ctrl.sv
module frame_timing_ctrl
  import frame_timing_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pixEn,
  input  status_t stat,
  output strobe_t strb,
  output logic    fv,
  output logic    lv,
  output logic    sof
);

  phase_t phase;
  phase_t nextPhase;
  phase_t firstPhase;

  always_comb begin
    if (stat.candVbNz)       firstPhase = PH_VBLANK;
    else if (stat.candDlyNz) firstPhase = PH_EXTRA;
    else                     firstPhase = PH_ACTIVE;
  end

  always_comb begin
    strb      = '0;
    nextPhase = phase;
    if (pixEn) begin
      unique case (phase)
        PH_LOAD: begin
          strb.load   = 1'b1;
          strb.colClr = 1'b1;
          strb.rowClr = 1'b1;
          nextPhase   = firstPhase;
        end
        PH_VBLANK: begin
          if (stat.colAtRowEnd) begin
            strb.colClr = 1'b1;
            if (stat.rowAtVEnd) begin
              strb.rowClr = 1'b1;
              nextPhase   = stat.shDlyNz ? PH_EXTRA : PH_ACTIVE;
            end else begin
              strb.rowInc = 1'b1;
            end
          end else begin
            strb.colInc = 1'b1;
          end
        end
        PH_EXTRA: begin
          if (stat.colAtDlyEnd) begin
            strb.colClr = 1'b1;
            nextPhase   = PH_ACTIVE;
          end else begin
            strb.colInc = 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (stat.colAtRowEnd) begin
            strb.colClr = 1'b1;
            if (stat.rowAtActEnd) begin
              strb.rowClr = 1'b1;
              strb.load   = 1'b1;
              nextPhase   = firstPhase;
            end else begin
              strb.rowInc = 1'b1;
            end
          end else begin
            strb.colInc = 1'b1;
          end
        end
        default: nextPhase = PH_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_LOAD;
    else       phase <= nextPhase;
  end

  always_comb begin
    fv  = (phase == PH_ACTIVE);
    lv  = fv && stat.inActiveCols;
    sof = fv && pixEn && stat.atOrigin;
  end

endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import frame_timing_pkg::*;
#(
  parameter int COL_W       = 12,
  parameter int ROW_W       = 12,
  parameter int HB_W        = 11,
  parameter int VB_W        = 15,
  parameter int DARK_W      = 8,
  parameter int DLY_W       = 14,
  parameter int HB_MIN_FULL = 202,
  parameter int HB_MIN_LOW  = 114,
  localparam int LEN_W      = ((HB_W > COL_W) ? HB_W : COL_W) + 1,
  localparam int CCNT_W     = (LEN_W > DLY_W) ? LEN_W : DLY_W,
  localparam int VMAX_W     = (VB_W > DARK_W) ? VB_W : DARK_W,
  localparam int RCNT_W     = (VMAX_W > ROW_W) ? VMAX_W : ROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic [COL_W-1:0]  activeWidth,
  input  logic [ROW_W-1:0]  activeHeight,
  input  logic [HB_W-1:0]   hBlank,
  input  logic [VB_W-1:0]   vBlank,
  input  logic [DARK_W-1:0] darkRows,
  input  logic [DLY_W-1:0]  extraDelay,
  input  logic              lowPower,
  output logic              fv,
  output logic              lv,
  output logic              sof,
  output logic [RCNT_W-1:0] rowIdx,
  output logic [CCNT_W-1:0] colIdx
);

  strobe_t strb;
  status_t stat;

  frame_timing_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .pixEn(pixEn),
    .stat (stat),
    .strb (strb),
    .fv   (fv),
    .lv   (lv),
    .sof  (sof)
  );

  frame_timing_path #(
    .COL_W(COL_W), .ROW_W(ROW_W), .HB_W(HB_W), .VB_W(VB_W),
    .DARK_W(DARK_W), .DLY_W(DLY_W),
    .HB_MIN_FULL(HB_MIN_FULL), .HB_MIN_LOW(HB_MIN_LOW),
    .LEN_W(LEN_W), .CCNT_W(CCNT_W), .VMAX_W(VMAX_W), .RCNT_W(RCNT_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .activeWidth (activeWidth),
    .activeHeight(activeHeight),
    .hBlank      (hBlank),
    .vBlank      (vBlank),
    .darkRows    (darkRows),
    .extraDelay  (extraDelay),
    .lowPower    (lowPower),
    .stat        (stat),
    .rowCnt      (rowIdx),
    .colCnt      (colIdx)
  );

endmodule

// File: rtl/frame_timing_checker.sv
module frame_timing_checker #(
  parameter int CW  = 14,
  parameter int RW  = 15,
  parameter int HBL = 114
) (
  input logic          clk,
  input logic          rstN,
  input logic          pixEn,
  input logic          fv,
  input logic          lv,
  input logic          sof,
  input logic [RW-1:0] rowIdx,
  input logic [CW-1:0] colIdx
);

  // R3: line valid only inside a valid frame
  p_lv_in_fv_r3: assert property (@(posedge clk) disable iff (!rstN)
    lv |-> fv);

  // R2: active columns never start before the smallest blanking minimum
  p_lv_after_blank_r2: assert property (@(posedge clk) disable iff (!rstN)
    lv |-> (colIdx >= CW'(HBL)));

  // R2: column counter steps by one or wraps to zero on an enabled cycle
  p_col_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |=> ((colIdx == CW'($past(colIdx) + CW'(1))) || (colIdx == '0)));

  // R8: everything holds while the enable is low
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> ($stable(fv) && $stable(lv) && $stable(rowIdx) && $stable(colIdx)));

  // R8: no start pulse without the enable
  p_sof_needs_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    sof |-> pixEn);

  // R7: start pulse only at the origin of the active rows
  p_sof_origin_r7: assert property (@(posedge clk) disable iff (!rstN)
    sof |-> (fv && (rowIdx == '0) && (colIdx == '0)));

  // R3: frame valid rises at the first column of the first active row
  p_fv_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fv) |-> ((rowIdx == '0) && (colIdx == '0)));

endmodule

bind frame_timing_gen frame_timing_checker #(
  .CW(CCNT_W), .RW(RCNT_W), .HBL(HB_MIN_LOW)
) u_chk (
  .clk(clk), .rstN(rstN), .pixEn(pixEn), .fv(fv), .lv(lv), .sof(sof),
  .rowIdx(rowIdx), .colIdx(colIdx)
);

// File: tb/test_frame_timing_gen.sv
module test_frame_timing_gen;

  typedef struct {
    int w, h, hb, vb, dark, dly;
    bit lp;
  } cfg_t;

  typedef struct {
    bit    fv, lv, sof;
    int    row, col;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixEn = 1'b0;
  logic [11:0] activeWidth;
  logic [11:0] activeHeight;
  logic [10:0] hBlank;
  logic [14:0] vBlank;
  logic [7:0]  darkRows;
  logic [13:0] extraDelay;
  logic        lowPower;
  logic        fv, lv, sof;
  logic [14:0] rowIdx;
  logic [13:0] colIdx;

  int    errors = 0;
  int    checks = 0;
  item_t expQ[$];
  cfg_t  drvCfg, frCur, frNxt, junkCfg;
  bit    frJunk;
  int    frGap;
  int    pixCount;
  string frNote;

  always #4 clk = ~clk;   // 125 MHz

  frame_timing_gen i_frame_timing_gen (
    .clk(clk), .rstN(rstN), .pixEn(pixEn),
    .activeWidth(activeWidth), .activeHeight(activeHeight),
    .hBlank(hBlank), .vBlank(vBlank), .darkRows(darkRows),
    .extraDelay(extraDelay), .lowPower(lowPower),
    .fv(fv), .lv(lv), .sof(sof), .rowIdx(rowIdx), .colIdx(colIdx)
  );

  task automatic applyCfg(cfg_t c);
    activeWidth  = 12'(c.w);
    activeHeight = 12'(c.h);
    hBlank       = 11'(c.hb);
    vBlank       = 15'(c.vb);
    darkRows     = 8'(c.dark);
    extraDelay   = 14'(c.dly);
    lowPower     = c.lp;
  endtask

  task automatic compare(item_t e);
    checks++;
    if (fv !== e.fv || lv !== e.lv || sof !== e.sof ||
        int'(rowIdx) != e.row || int'(colIdx) != e.col) begin
      errors++;
      $display("FAIL %s %s: fv/lv/sof/row/col actual %0b/%0b/%0b/%0d/%0d expected %0b/%0b/%0b/%0d/%0d",
               e.tag, frNote, fv, lv, sof, rowIdx, colIdx, e.fv, e.lv, e.sof, e.row, e.col);
    end
  endtask

  // Driver: one expected item per clock cycle
  task automatic driveCycle(bit en, item_t it);
    @(posedge clk);
    #1;
    pixEn = en;
    applyCfg(drvCfg);
    expQ.push_back(it);
  endtask

  task automatic emit(bit efv, bit elv, int r, int c, string tag, bit isLast);
    item_t it;
    item_t gi;
    it.fv  = efv;
    it.lv  = elv;
    it.row = r;
    it.col = c;
    it.sof = efv && (r == 0) && (c == 0);
    it.tag = it.sof ? "R7" : tag;
    drvCfg = isLast ? frNxt : (frJunk ? junkCfg : frCur);
    if (frGap > 0 && (pixCount % frGap) == frGap - 1) begin
      gi     = it;
      gi.sof = 1'b0;
      gi.tag = "R8";
      driveCycle(1'b0, gi);
    end
    driveCycle(1'b1, it);
    pixCount++;
  endtask

  task automatic playFrame(cfg_t c, cfg_t n, bit junk, int gap, string note);
    int hMin, hE, vE, wE, hgt, len;
    frCur = c; frNxt = n; frJunk = junk; frGap = gap; frNote = note; pixCount = 0;
    hMin = c.lp ? 114 : 202;
    hE   = (c.hb < hMin) ? hMin : c.hb;
    vE   = (c.vb < c.dark) ? c.dark : c.vb;
    wE   = (c.w == 0) ? 1 : c.w;
    hgt  = (c.h == 0) ? 1 : c.h;
    len  = hE + wE;
    for (int r = 0; r < vE; r++)
      for (int col = 0; col < len; col++)
        emit(1'b0, 1'b0, r, col, "R4", 1'b0);
    for (int col = 0; col < c.dly; col++)
      emit(1'b0, 1'b0, 0, col, "R5", 1'b0);
    for (int r = 0; r < hgt; r++)
      for (int col = 0; col < len; col++)
        emit(1'b1, col >= hE, r, col, (col >= hE) ? "R3" : "R2",
             (r == hgt - 1) && (col == len - 1));
  endtask

  // Monitor: pop and compare mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  task automatic runAll();
    cfg_t cfgs[5];
    item_t z;
    cfgs[0] = '{w: 4, h: 3, hb: 0,   vb: 2, dark: 0, dly: 3, lp: 1'b0}; // clamp to 202
    cfgs[1] = '{w: 5, h: 2, hb: 5,   vb: 1, dark: 3, dly: 0, lp: 1'b1}; // clamp 114, dark raises vb
    cfgs[2] = '{w: 0, h: 2, hb: 250, vb: 0, dark: 0, dly: 0, lp: 1'b0}; // zero width, no vblank
    cfgs[3] = '{w: 2, h: 0, hb: 114, vb: 1, dark: 0, dly: 1, lp: 1'b1}; // exact low minimum
    cfgs[4] = '{w: 3, h: 1, hb: 202, vb: 0, dark: 2, dly: 0, lp: 1'b0}; // exact full minimum
    junkCfg = '{w: 9, h: 1, hb: 300, vb: 7, dark: 9, dly: 50, lp: 1'b1};
    frNote  = "reset";
    drvCfg  = cfgs[0];
    applyCfg(cfgs[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    z.fv = 0; z.lv = 0; z.sof = 0; z.row = 0; z.col = 0; z.tag = "R1";
    compare(z);
    @(posedge clk);
    #1 rstN = 1'b1;
    driveCycle(1'b0, z);          // R1: idle after reset
    driveCycle(1'b0, z);
    driveCycle(1'b1, z);          // R1: capture cycle
    playFrame(cfgs[0], cfgs[1], 1'b1, 0, "frame0 R6");
    playFrame(cfgs[1], cfgs[2], 1'b0, 0, "frame1");
    playFrame(cfgs[2], cfgs[3], 1'b1, 3, "frame2 R9 R6 R8");
    playFrame(cfgs[3], cfgs[4], 1'b0, 0, "frame3 R9");
    playFrame(cfgs[4], cfgs[4], 1'b1, 0, "frame4 R6");
    drvCfg = cfgs[4];
    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule